// File: doc/BRIEF.md
# Buffer Enquiry and Packet Responder

This block is the receive-side reply logic of a node on a token-passing network. A frame decoder in front of it reports each incoming frame as a one-cycle event. The event carries a frame kind and a destination ID. The block compares the destination with the node's own ID and drops anything meant for another node. When another node asks whether this one has a free buffer, the block asks the line transmitter to send a positive reply if reception is enabled, and a negative reply if it is not.

When a data packet addressed to the node arrives while reception is enabled, the block arms itself and waits for the CRC checker's verdict. If the CRC passes, it requests a positive reply. It also closes the receiver, so that further enquiries are refused until the host opens it again, and it raises a receive-complete flag. That flag drives the interrupt output through a host mask. If the CRC fails, the block stays silent and leaves reception open.

Top module: `pktResponder`

## Requirements
- R1: An enquiry frame (kind 2'b00) whose destination equals `nodeId`, received while `rxEnabled` is 1, gives a one-cycle `replyReq` pulse in the cycle after the frame strobe, with `replyAck` = 1 (positive reply).
- R2: The same enquiry received while `rxEnabled` is 0 gives the `replyReq` pulse with `replyAck` = 0 (negative reply).
- R3: A frame of any kind whose destination differs from `nodeId` produces no `replyReq`, and it leaves `rxEnabled` and `rxDone` unchanged.
- R4: A data frame (kind 2'b01) for this node, received while `rxEnabled` is 1, arms the block. The next `crcValid` strobe with `crcOk` = 1 then gives a `replyReq` pulse with `replyAck` = 1 in the following cycle.
- R5: An armed packet whose `crcValid` strobe comes with `crcOk` = 0 produces no `replyReq`, leaves `rxEnabled` at 1 and `rxDone` at 0, and disarms the block.
- R6: Accepting a good packet clears `rxEnabled` in the same cycle as the reply appears, so later enquiries get a negative reply.
- R7: Accepting a good packet sets `rxDone`. `irq` equals `rxDone` AND `irqMask`.
- R8: A `hostEnable` pulse sets `rxEnabled` and clears `rxDone`. A `hostDisable` pulse clears `rxEnabled`. When a packet is accepted in the same cycle as a host pulse, the acceptance takes priority.
- R9: Frames of kind 2'b10 or 2'b11 never produce a reply. A data frame received while `rxEnabled` is 0 is ignored. A `crcValid` strobe with no armed packet produces no reply and changes no state.
- R10: After reset, `replyReq`, `rxEnabled`, `rxDone` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeId | input | ID_W | This node's address |
| frameValid | input | 1 | One-cycle strobe: a decoded frame is present |
| frameKind | input | 2 | 00 enquiry, 01 data, 10/11 other |
| frameDest | input | ID_W | Destination ID of the decoded frame |
| crcValid | input | 1 | One-cycle strobe: CRC verdict for the last data frame |
| crcOk | input | 1 | CRC verdict, 1 = good |
| hostEnable | input | 1 | Pulse: open the receiver, clear receive-complete |
| hostDisable | input | 1 | Pulse: inhibit the receiver |
| irqMask | input | 1 | Interrupt enable for receive-complete |
| replyReq | output | 1 | One-cycle request to the line transmitter |
| replyAck | output | 1 | Reply kind with `replyReq`: 1 positive, 0 negative |
| rxEnabled | output | 1 | Receiver open |
| rxDone | output | 1 | Receive-complete status |
| irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps every destination ID against every frame kind, once with the receiver open and once with it inhibited. A design that matched addresses loosely would answer foreign enquiries. A design that ignored the inhibit state would give a positive reply where a negative one is due. Each data frame is followed by a failing CRC, which catches a design that sends a negative reply, or closes the receiver, on a bad packet. Good-packet sequences then check that the receiver closes, that the following enquiry is refused, and that the mask gates the interrupt. A stray CRC strobe, and a data frame sent while inhibited, check that a design without proper arming stays silent.

// File: rtl/pktResponderPkg.sv
package pktResponderPkg;

  localparam logic [1:0] KIND_ENQ  = 2'b00;
  localparam logic [1:0] KIND_DATA = 2'b01;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } armStateE;

  typedef struct packed {
    logic sendReply;
    logic replyAck;
    logic accept;
  } ctrlStrobesT;

endpackage

// File: rtl/pktResponderCtrl.sv
module pktResponderCtrl
  import pktResponderPkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ID_W-1:0] nodeId,
  input  logic            frameValid,
  input  logic [1:0]      frameKind,
  input  logic [ID_W-1:0] frameDest,
  input  logic            crcValid,
  input  logic            crcOk,
  input  logic            rxEnabled,
  output ctrlStrobesT     strobes
);

  armStateE state, nextState;
  logic destHit, enqHit, armHit, crcEval, goodPkt;

  always_comb begin
    destHit = frameValid && (frameDest == nodeId);
    enqHit  = destHit && (frameKind == KIND_ENQ);
    armHit  = destHit && (frameKind == KIND_DATA) && rxEnabled;
    crcEval = crcValid && (state == ST_WAIT);
    goodPkt = crcEval && crcOk;
  end

  // A good packet's reply takes precedence over a coincident enquiry.
  always_comb begin
    strobes.sendReply = enqHit || goodPkt;
    strobes.replyAck  = goodPkt || (enqHit && rxEnabled);
    strobes.accept    = goodPkt;
  end

  always_comb begin
    nextState = state;
    if (armHit)       nextState = ST_WAIT;
    else if (crcEval) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  AST_ARM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_WAIT) |-> ($past(rxEnabled) && $past(frameValid))) // R4
    else $error("armed without an enabled receiver");

  AST_ACCEPT_ONLY_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |-> (state == ST_WAIT)) // R9
    else $error("packet accepted while not armed");

endmodule

// File: rtl/pktResponderData.sv
module pktResponderData
  import pktResponderPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobesT strobes,
  input  logic        hostEnable,
  input  logic        hostDisable,
  input  logic        irqMask,
  output logic        replyReq,
  output logic        replyAck,
  output logic        rxEnabled,
  output logic        rxDone,
  output logic        irq
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      replyReq <= 1'b0;
      replyAck <= 1'b0;
    end else begin
      replyReq <= strobes.sendReply;
      replyAck <= strobes.sendReply && strobes.replyAck;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEnabled <= 1'b0;
      rxDone    <= 1'b0;
    end else if (strobes.accept) begin
      rxEnabled <= 1'b0;
      rxDone    <= 1'b1;
    end else begin
      if (hostDisable)     rxEnabled <= 1'b0;
      else if (hostEnable) rxEnabled <= 1'b1;
      if (hostEnable)      rxDone    <= 1'b0;
    end
  end

  always_comb irq = rxDone && irqMask;

  AST_NAK_ONLY_IF_INHIBITED: assert property (@(posedge clk) disable iff (!rstN)
    (replyReq && !replyAck) |-> !$past(rxEnabled)) // R2
    else $error("negative reply while receiver open");

  AST_ACCEPT_CLOSES_RX: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> (!rxEnabled && replyReq && replyAck)) // R6
    else $error("accept did not close receiver");

  AST_ACCEPT_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> rxDone) // R7
    else $error("accept did not set rxDone");

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !hostEnable) |=> rxDone) // R8
    else $error("rxDone dropped without host enable");

endmodule

// File: rtl/pktResponder.sv
module pktResponder
  import pktResponderPkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ID_W-1:0] nodeId,
  input  logic            frameValid,
  input  logic [1:0]      frameKind,
  input  logic [ID_W-1:0] frameDest,
  input  logic            crcValid,
  input  logic            crcOk,
  input  logic            hostEnable,
  input  logic            hostDisable,
  input  logic            irqMask,
  output logic            replyReq,
  output logic            replyAck,
  output logic            rxEnabled,
  output logic            rxDone,
  output logic            irq
);

  ctrlStrobesT strobes;

  pktResponderCtrl #(.ID_W(ID_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .nodeId     (nodeId),
    .frameValid (frameValid),
    .frameKind  (frameKind),
    .frameDest  (frameDest),
    .crcValid   (crcValid),
    .crcOk      (crcOk),
    .rxEnabled  (rxEnabled),
    .strobes    (strobes)
  );

  pktResponderData u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .hostEnable  (hostEnable),
    .hostDisable (hostDisable),
    .irqMask     (irqMask),
    .replyReq    (replyReq),
    .replyAck    (replyAck),
    .rxEnabled   (rxEnabled),
    .rxDone      (rxDone),
    .irq         (irq)
  );

  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && (frameDest != nodeId) && !crcValid) |=> !replyReq) // R3
    else $error("reply to a foreign frame");

endmodule

// File: tb/pktResponder_tb.sv
module pktResponder_tb;

  localparam int ID_W = 8;
  localparam logic [ID_W-1:0] NODE = 8'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ID_W-1:0] nodeId = NODE;
  logic frameValid = 1'b0;
  logic [1:0] frameKind = 2'b00;
  logic [ID_W-1:0] frameDest = '0;
  logic crcValid = 1'b0, crcOk = 1'b0;
  logic hostEnable = 1'b0, hostDisable = 1'b0, irqMask = 1'b0;
  logic replyReq, replyAck, rxEnabled, rxDone, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pktResponder #(.ID_W(ID_W)) u_dut (
    .clk(clk), .rstN(rstN), .nodeId(nodeId), .frameValid(frameValid),
    .frameKind(frameKind), .frameDest(frameDest), .crcValid(crcValid),
    .crcOk(crcOk), .hostEnable(hostEnable), .hostDisable(hostDisable),
    .irqMask(irqMask), .replyReq(replyReq), .replyAck(replyAck),
    .rxEnabled(rxEnabled), .rxDone(rxDone), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Each task leaves the strobe up for one edge and samples at the next negedge.
  task automatic sendFrame(input logic [1:0] k, input logic [ID_W-1:0] d);
    @(negedge clk);
    frameValid = 1'b1; frameKind = k; frameDest = d;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic sendCrc(input logic ok);
    @(negedge clk);
    crcValid = 1'b1; crcOk = ok;
    @(negedge clk);
    crcValid = 1'b0;
  endtask

  task automatic hostPulse(input logic en, input logic dis);
    @(negedge clk);
    hostEnable = en; hostDisable = dis;
    @(negedge clk);
    hostEnable = 1'b0; hostDisable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 replyReq after reset", replyReq, 1'b0);
    chk("R10 rxEnabled after reset", rxEnabled, 1'b0);
    chk("R10 rxDone after reset", rxDone, 1'b0);
    chk("R10 irq after reset", irq, 1'b0);

    // Sweep: receiver state x frame kind x every destination
    for (int en = 0; en < 2; en++) begin
      if (en == 1) hostPulse(1'b1, 1'b0);
      else         hostPulse(1'b0, 1'b1);
      chk("R8 host control", rxEnabled, en[0]);
      for (int k = 0; k < 4; k++) begin
        for (int d = 0; d < 256; d++) begin
          logic hit, expReq, expArm;
          hit    = (d[7:0] == NODE);
          expReq = hit && (k == 0);
          expArm = hit && (k == 1) && (en == 1);
          sendFrame(k[1:0], d[7:0]);
          if (!hit)       chk("R3 foreign frame silent", replyReq, 1'b0);
          else if (k > 1) chk("R9 other kind silent", replyReq, 1'b0);
          else            chk("R1/R2 enquiry reply", replyReq, expReq);
          if (expReq && en == 1) chk("R1 positive reply", replyAck, 1'b1);
          if (expReq && en == 0) chk("R2 negative reply", replyAck, 1'b0);
          if (k == 1) begin
            sendCrc(1'b0);
            if (expArm) chk("R5 bad crc silent", replyReq, 1'b0);
            else        chk("R9 unarmed crc silent", replyReq, 1'b0);
            chk("R5 receiver unchanged", rxEnabled, en[0]);
            chk("R3 rxDone unchanged", rxDone, 1'b0);
          end
        end
      end
    end

    // Good packet with mask off then on
    hostPulse(1'b1, 1'b0);
    irqMask = 1'b0;
    sendFrame(2'b01, NODE);
    chk("R4 no reply on data frame", replyReq, 1'b0);
    sendCrc(1'b1);
    chk("R4 good packet reply", replyReq, 1'b1);
    chk("R4 good packet ack", replyAck, 1'b1);
    chk("R6 receiver closed", rxEnabled, 1'b0);
    chk("R7 rxDone set", rxDone, 1'b1);
    chk("R7 irq masked", irq, 1'b0);
    irqMask = 1'b1;
    @(negedge clk);
    chk("R7 irq unmasked", irq, 1'b1);
    chk("R4 reply is one pulse", replyReq, 1'b0);
    sendFrame(2'b00, NODE);
    chk("R6 enquiry after packet", replyReq, 1'b1);
    chk("R6 negative after packet", replyAck, 1'b0);
    sendCrc(1'b1);
    chk("R9 second crc silent", replyReq, 1'b0);
    chk("R9 second crc no state", rxDone, 1'b1);

    // Data frame while inhibited is ignored
    sendFrame(2'b01, NODE);
    sendCrc(1'b1);
    chk("R9 inhibited data silent", replyReq, 1'b0);
    chk("R9 inhibited data enable", rxEnabled, 1'b0);

    // Re-enable clears status, enquiry answered positively again
    hostPulse(1'b1, 1'b0);
    chk("R8 enable sets rxEnabled", rxEnabled, 1'b1);
    chk("R8 enable clears rxDone", rxDone, 1'b0);
    chk("R7 irq follows rxDone", irq, 1'b0);
    sendFrame(2'b00, NODE);
    chk("R1 enquiry after re-enable", replyAck & replyReq, 1'b1);

    // Acceptance wins over a coincident host enable
    sendFrame(2'b01, NODE);
    @(negedge clk);
    crcValid = 1'b1; crcOk = 1'b1; hostEnable = 1'b1;
    @(negedge clk);
    crcValid = 1'b0; hostEnable = 1'b0;
    chk("R8 accept priority enable", rxEnabled, 1'b0);
    chk("R8 accept priority done", rxDone, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule